// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This engine stores received Ethernet frames in a circular buffer held in a word-wide memory that has byte enables. Frames arrive one byte at a time, and the final byte carries a set of error flags. For each frame the engine reserves a 4-byte header slot and puts a busy marker in the length half of that slot. It then streams the payload behind the header, wrapping to offset 0 at the end of the ring. After the last payload byte is stored, it writes the final status and length. The next header starts at the following 4-byte aligned offset.

A host consumes frames and advances its read position through a register that holds the read offset minus 16. The engine adds the bias back, modulo the ring size, to get the true read offset. It reports buffer-empty when the read and write offsets are equal. A frame that would fill the ring up to the read offset is discarded. In that case the write offset does not move and an overflow event is raised. A 2-bit select chooses a ring of 8, 16, 32 or 64 KB. The backing memory is expected to have 16 spare bytes beyond the ring, but the engine never writes them. At least two idle input cycles must separate consecutive frames.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, buf_empty is 1, rdp_q reads 0xFFF0, no memory write is issued and no event is raised.
- R2: The final header is little-endian. Bytes 0-1 hold the 16-bit status and bytes 2-3 hold the 16-bit length. The length is the count of all bytes received for the frame, trailing CRC included.
- R3: When the first byte of a frame is taken, header bytes 2-3 are written with 0xFFF0 (low byte 0xF0 first). The final header is written after the last payload byte, in the same cycle as the frame's event.
- R4: Payload byte i is stored at offset (header + 4 + i) mod ring size. Bytes past the ring end therefore continue at offset 0.
- R5: The next frame's header starts at header + roundup4(4 + length), modulo the ring size.
- R6: Status bit 0 is 1 when in_flags is all zero. in_flags bits 0..4 (alignment, CRC, too long, runt, invalid symbol) appear as status bits 1..5. Status bits 6..15 are 0.
- R7: A stored frame raises a one-cycle pulse: evt_rx_ok if its flags are all zero, otherwise evt_rx_err. At most one event is active in any cycle.
- R8: A pulse on rdp_wr loads rdp_wdata into rdp_q. The read offset is (rdp_q + 16) mod ring size.
- R9: buf_empty is 1 exactly when the read offset equals the write offset. It reflects a change in the cycle after the change is applied.
- R10: ring_sel values 0, 1, 2 and 3 select ring sizes of 8192, 16384, 32768 and 65536 bytes.
- R11: A frame is dropped when used + roundup4(4 + length) ≥ ring size, where used = (write − read) mod ring. A dropped frame raises evt_ovf and leaves the write offset unchanged. No payload byte of any frame lands at or beyond the read offset.
- R12: A host pointer write and a frame commit in the same cycle both take effect. buf_empty then compares the new read offset with the new write offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_sel | input | 2 | Ring size select |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_flags | input | 5 | Error flags, sampled with the last byte |
| rdp_wr | input | 1 | Host read-pointer write strobe |
| rdp_wdata | input | 16 | Host read-pointer value (offset − 16) |
| rdp_q | output | 16 | Host read-pointer register |
| buf_empty | output | 1 | Read offset equals write offset |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Memory word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| evt_rx_ok | output | 1 | Frame stored without error flags |
| evt_rx_err | output | 1 | Frame stored with error flags |
| evt_ovf | output | 1 | Frame dropped, ring full |

## Verification
Two things can happen in the same cycle: the host moves its read pointer, and the engine commits a frame and advances its write offset. Both feed the empty decision. The bench provokes this by timing a host write to land on the exact edge where a frame's final header is written. It sets that write to the offset the commit will produce. It then expects buf_empty to rise, the ok event to have fired and the header to carry the true length. Overflow exercises a similar interaction, because the fit test reads the host offset while a frame is arriving.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_FLUSH, RX_COMMIT} rx_state_e;
  localparam int          HDR_BYTES = 4;
  localparam int          PTR_BIAS  = 16;
  localparam logic [15:0] LEN_BUSY  = 16'hFFF0;
endpackage

// File: rtl/rxr_host_ptr.sv
module rxr_host_ptr #(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OFF_W-1:0] wdata,
  input  logic [OFF_W-1:0] mask,
  output logic [OFF_W-1:0] reg_q,
  output logic [OFF_W-1:0] rd_off,
  output logic [OFF_W-1:0] rd_off_nxt
);
  localparam logic [OFF_W-1:0] BIAS    = OFF_W'(rxr_pkg::PTR_BIAS);
  localparam logic [OFF_W-1:0] RST_VAL = OFF_W'(0) - BIAS;

  always_ff @(posedge clk) begin
    if (rst)     reg_q <= RST_VAL;
    else if (wr) reg_q <= wdata;
  end

  assign rd_off     = (reg_q + BIAS) & mask;
  assign rd_off_nxt = ((wr ? wdata : reg_q) + BIAS) & mask;
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int OFF_W = 16,
  parameter int LEN_W = 16
) (
  input  logic [OFF_W-1:0] wptr,
  input  logic [OFF_W-1:0] rd_off,
  input  logic [OFF_W-1:0] mask,
  input  logic [LEN_W-1:0] cnt,
  output logic             byte_fits,
  output logic             frame_fits,
  output logic [OFF_W-1:0] adv
);
  localparam int EW = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;

  logic [EW-1:0] used, ring, pos, tot;

  assign used       = EW'((wptr - rd_off) & mask);
  assign ring       = EW'(mask) + EW'(1);
  assign pos        = EW'(cnt) + EW'(rxr_pkg::HDR_BYTES);
  assign tot        = (pos + EW'(3)) & ~EW'(3);
  assign byte_fits  = (used + pos) < ring;
  assign frame_fits = (used + tot) < ring;
  assign adv        = tot[OFF_W-1:0] & mask;
endmodule

// File: rtl/rxr_lane_fmt.sv
module rxr_lane_fmt #(
  parameter int OFF_W = 16
) (
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       data,
  output logic [OFF_W-3:0] waddr,
  output logic [3:0]       be,
  output logic [31:0]      wdata
);
  assign waddr = off[OFF_W-1:2];

  generate
    for (genvar g = 0; g < 4; g++) begin : g_lane
      assign be[g]           = (off[1:0] == 2'(g));
      assign wdata[8*g +: 8] = data;
    end
  endgenerate
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int  MIN_LOG = 13,
  parameter int  SEL_W   = 2,
  parameter int  FLAG_W  = 5,
  localparam int OFF_W   = MIN_LOG + (1 << SEL_W) - 1,
  localparam int LEN_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  ring_sel,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic              rdp_wr,
  input  logic [OFF_W-1:0]  rdp_wdata,
  output logic [OFF_W-1:0]  rdp_q,
  output logic              buf_empty,
  output logic              mem_we,
  output logic [OFF_W-3:0]  mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic              evt_rx_ok,
  output logic              evt_rx_err,
  output logic              evt_ovf
);
  import rxr_pkg::*;

  rx_state_e         st;
  logic [OFF_W:0]    ring_sz;
  logic [OFF_W-1:0]  ring_mask, wptr, wptr_nxt, rd_off, rd_off_nxt;
  logic [OFF_W-1:0]  pay_off, adv, pend_off;
  logic [LEN_W-1:0]  cnt;
  logic [7:0]        pend_byte;
  logic              pend_ok, byte_fits, frame_fits;
  logic [FLAG_W-1:0] flags_q;
  logic [OFF_W-3:0]  b_addr;
  logic [3:0]        b_be;
  logic [31:0]       b_data;
  logic [15:0]       status_w;

  assign ring_sz   = (OFF_W+1)'(1) << (MIN_LOG + int'(ring_sel));
  assign ring_mask = OFF_W'(ring_sz - (OFF_W+1)'(1));
  assign pay_off   = (wptr + OFF_W'(HDR_BYTES) + OFF_W'(cnt)) & ring_mask;
  assign status_w  = {{(15-FLAG_W){1'b0}}, flags_q, (flags_q == '0)};
  assign wptr_nxt  = (st == RX_COMMIT && frame_fits) ? ((wptr + adv) & ring_mask) : wptr;

  rxr_host_ptr #(.OFF_W(OFF_W)) u_hptr (
    .clk(clk), .rst(rst), .wr(rdp_wr), .wdata(rdp_wdata), .mask(ring_mask),
    .reg_q(rdp_q), .rd_off(rd_off), .rd_off_nxt(rd_off_nxt)
  );

  rxr_space #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_space (
    .wptr(wptr), .rd_off(rd_off), .mask(ring_mask), .cnt(cnt),
    .byte_fits(byte_fits), .frame_fits(frame_fits), .adv(adv)
  );

  rxr_lane_fmt #(.OFF_W(OFF_W)) u_fmt (
    .off(pend_off), .data(pend_byte), .waddr(b_addr), .be(b_be), .wdata(b_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      wptr       <= '0;
      cnt        <= '0;
      pend_byte  <= '0;
      pend_off   <= '0;
      pend_ok    <= 1'b0;
      flags_q    <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      evt_rx_ok  <= 1'b0;
      evt_rx_err <= 1'b0;
      evt_ovf    <= 1'b0;
      buf_empty  <= 1'b1;
    end else begin
      mem_we     <= 1'b0;
      evt_rx_ok  <= 1'b0;
      evt_rx_err <= 1'b0;
      evt_ovf    <= 1'b0;
      wptr       <= wptr_nxt;
      buf_empty  <= (rd_off_nxt == wptr_nxt);
      unique case (st)
        RX_IDLE, RX_BODY: begin
          if (in_valid) begin
            if (st == RX_IDLE) begin
              // reserve the header slot with the busy length marker
              mem_we    <= 1'b1;
              mem_addr  <= wptr[OFF_W-1:2];
              mem_be    <= 4'b1100;
              mem_wdata <= {LEN_BUSY, 16'h0000};
            end else begin
              mem_we    <= pend_ok;
              mem_addr  <= b_addr;
              mem_be    <= b_be;
              mem_wdata <= b_data;
            end
            pend_byte <= in_data;
            pend_off  <= pay_off;
            pend_ok   <= byte_fits;
            cnt       <= cnt + 1'b1;
            if (in_last) begin
              flags_q <= in_flags;
              st      <= RX_FLUSH;
            end else begin
              st      <= RX_BODY;
            end
          end
        end
        RX_FLUSH: begin
          mem_we    <= pend_ok;
          mem_addr  <= b_addr;
          mem_be    <= b_be;
          mem_wdata <= b_data;
          st        <= RX_COMMIT;
        end
        RX_COMMIT: begin
          if (frame_fits) begin
            mem_we     <= 1'b1;
            mem_addr   <= wptr[OFF_W-1:2];
            mem_be     <= 4'b1111;
            mem_wdata  <= {cnt, status_w};
            evt_rx_ok  <= (flags_q == '0);
            evt_rx_err <= (flags_q != '0);
          end else begin
            evt_ovf    <= 1'b1;
          end
          cnt <= '0;
          st  <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
  input logic        clk,
  input logic        rst,
  input logic        buf_empty,
  input logic        rdp_wr,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        evt_rx_ok,
  input logic        evt_rx_err,
  input logic        evt_ovf
);
  // R7
  evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_rx_ok, evt_rx_err, evt_ovf}));

  // R3
  commit_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_rx_ok || evt_rx_err) |-> (mem_we && mem_be == 4'hF));

  // R3
  busy_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be == 4'b1100) |-> (mem_wdata[31:16] == 16'hFFF0));

  // R4
  lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be != 4'b1100 && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  // R11
  drop_no_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    evt_ovf |-> !(mem_we && mem_be == 4'hF));

  // R9
  empty_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(buf_empty) |-> ($past(rdp_wr) || evt_rx_ok || evt_rx_err));
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (
  .clk(clk), .rst(rst), .buf_empty(buf_empty), .rdp_wr(rdp_wr),
  .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .evt_rx_ok(evt_rx_ok), .evt_rx_err(evt_rx_err), .evt_ovf(evt_ovf)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ring_sel = 2'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic [4:0]  in_flags = 5'd0;
  logic        rdp_wr = 1'b0;
  logic [15:0] rdp_wdata = 16'h0000;
  logic [15:0] rdp_q;
  logic        buf_empty, mem_we, evt_rx_ok, evt_rx_err, evt_ovf;
  logic [13:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;

  int n_chk = 0, n_fail = 0;
  int cnt_ok = 0, cnt_err = 0, cnt_ovf = 0;
  logic [7:0] mem_m [int];

  rx_ring_writer dut (
    .clk(clk), .rst(rst), .ring_sel(ring_sel), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_flags(in_flags), .rdp_wr(rdp_wr), .rdp_wdata(rdp_wdata),
    .rdp_q(rdp_q), .buf_empty(buf_empty), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .evt_rx_ok(evt_rx_ok),
    .evt_rx_err(evt_rx_err), .evt_ovf(evt_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model and event counters
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we)
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem_m[int'({mem_addr, 2'(l)})] = mem_wdata[8*l +: 8];
      cnt_ok  += int'(evt_rx_ok);
      cnt_err += int'(evt_rx_err);
      cnt_ovf += int'(evt_ovf);
    end
  end

  function automatic int peek(input int a);
    if (mem_m.exists(a)) return int'(mem_m[a]);
    return 0;
  endfunction

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1;
    ring_sel = sel;
    repeat (3) @(negedge clk);
    mem_m.delete();
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_write(input int v);
    @(negedge clk);
    rdp_wr = 1'b1;
    rdp_wdata = 16'(v);
    @(negedge clk);
    rdp_wr = 1'b0;
  endtask

  // drives one frame; checks the busy marker at byte 8 when hdr >= 0
  task automatic drive_frame(input int len, input logic [4:0] flags, input int seed, input int hdr);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 8 && hdr >= 0) begin
        chk_eq("R3", "busy marker low", peek(hdr + 2), 'hF0);
        chk_eq("R3", "busy marker high", peek(hdr + 3), 'hFF);
      end
      in_valid = 1'b1;
      in_data  = 8'(seed + i);
      in_last  = (i == len - 1);
      in_flags = (i == len - 1) ? flags : 5'd0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_flags = 5'd0;
  endtask

  task automatic chk_header(input string req, input int hdr, input int st, input int len);
    chk_eq(req, "header status", (peek(hdr + 1) << 8) | peek(hdr), st);
    chk_eq(req, "header length", (peek(hdr + 3) << 8) | peek(hdr + 2), len);
  endtask

  task automatic chk_payload(input string req, input int hdr, input int len, input int seed, input int ring);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (peek((hdr + 4 + i) % ring) != ((seed + i) & 255)) bad++;
    chk_eq(req, "payload mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk_eq("R1", "empty after reset", int'(buf_empty), 1);
    chk_eq("R1", "host pointer after reset", int'(rdp_q), 'hFFF0);
    chk_eq("R1", "no write after reset", int'(mem_we), 0);
    chk_eq("R1", "no events after reset", cnt_ok + cnt_err + cnt_ovf, 0);
  endtask

  task automatic t_basic();
    int ok0 = cnt_ok;
    drive_frame(64, 5'd0, 'h10, 0);
    repeat (3) @(negedge clk);
    chk_header("R2", 0, 'h0001, 64);
    chk_payload("R4", 0, 64, 'h10, 8192);
    chk_eq("R7", "ok event count", cnt_ok - ok0, 1);
    chk_eq("R9", "not empty after frame", int'(buf_empty), 0);
  endtask

  task automatic t_flags();
    int er0 = cnt_err;
    drive_frame(61, 5'b00010, 'h20, 68);
    repeat (3) @(negedge clk);
    chk_header("R6", 68, 'h0004, 61);
    chk_eq("R7", "err event count", cnt_err - er0, 1);
    // R5: 68 + roundup4(65) = 136
    drive_frame(10, 5'b11001, 'h30, 136);
    repeat (3) @(negedge clk);
    chk_header("R5", 136, 'h0032, 10);
    chk_eq("R6", "multi-flag err events", cnt_err - er0, 2);
  endtask

  task automatic t_empty();
    // write offset is 136 + 16 = 152
    host_write(136);
    chk_eq("R9", "empty when offsets meet", int'(buf_empty), 1);
    chk_eq("R8", "host pointer readback", int'(rdp_q), 136);
  endtask

  task automatic t_overflow();
    int ok0, ov0;
    do_reset(2'd0);
    ok0 = cnt_ok;
    ov0 = cnt_ovf;
    for (int k = 0; k < 9; k++) begin
      drive_frame(1000, 5'd0, k * 7 + 3, k * 1004);
      repeat (3) @(negedge clk);
    end
    chk_eq("R11", "frames stored", cnt_ok - ok0, 8);
    chk_eq("R11", "overflow events", cnt_ovf - ov0, 1);
    chk_eq("R11", "unread byte intact", peek(4), 3);
    chk_payload("R4", 0, 1000, 3, 8192);
    host_write(8032 - 16);
    chk_eq("R11", "write offset unchanged after drop", int'(buf_empty), 1);
  endtask

  task automatic t_wrap_same();
    int ok0;
    drive_frame(200, 5'd0, 'h55, 8032);
    repeat (3) @(negedge clk);
    chk_header("R2", 8032, 'h0001, 200);
    chk_payload("R4", 8032, 200, 'h55, 8192);
    chk_eq("R9", "not empty after wrapped frame", int'(buf_empty), 0);
    ok0 = cnt_ok;
    drive_frame(20, 5'd0, 'h80, 44);
    @(negedge clk);
    rdp_wr = 1'b1;
    rdp_wdata = 16'(68 - 16);
    @(negedge clk);
    rdp_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk_eq("R12", "empty after same-cycle write", int'(buf_empty), 1);
    chk_eq("R12", "ok event on same cycle", cnt_ok - ok0, 1);
    chk_header("R12", 44, 'h0001, 20);
    chk_eq("R8", "host pointer after same-cycle", int'(rdp_q), 52);
  endtask

  task automatic t_size();
    do_reset(2'd1);
    host_write(8192 - 16);
    chk_eq("R10", "16K ring keeps 8192", int'(buf_empty), 0);
    do_reset(2'd0);
    host_write(8192 - 16);
    chk_eq("R10", "8K ring wraps 8192", int'(buf_empty), 1);
    do_reset(2'd3);
    host_write(32768 - 16);
    chk_eq("R10", "64K ring keeps 32768", int'(buf_empty), 0);
    do_reset(2'd2);
    host_write(32768 - 16);
    chk_eq("R10", "32K ring wraps 32768", int'(buf_empty), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_flags();
    t_empty();
    t_overflow();
    t_wrap_same();
    t_size();
    finish_run();
  end
endmodule